// File: doc/BRIEF.md
# Interrupt Redirection Controller

This block turns a set of device interrupt pins into interrupt messages for the processors of a system. Each pin has its own 64-bit routing entry. The entry gives the vector, the destination, whether the destination is one target ID or a bitmask of targets, the delivery mode, the input polarity, whether the pin is edge- or level-sensitive, and a mask bit. A message leaves the block on a valid/ready output and carries the fields of the entry of the pin that raised it.

Software reaches all state through two registers. It loads an 8-bit index, and then reads or writes the 32-bit word that the index selects. The block also holds an identification register, a fixed version word and an arbitration word that follows the identification field.

Level-sensitive pins keep a remote-service flag that is set when a message is accepted. An end-of-interrupt broadcast whose vector matches the entry clears the flag. If the input is still active at that point, the pin fires again. When several pins want service at once, one message is presented at a time, and the pins are scanned round-robin starting after the last pin served.

Top module: `irq_redirector`

## Requirements
- R1: Index 0x00 is the identification register and reads {4'b0, id[3:0], 24'b0}. A write changes only bits 27:24, and all other bits always read zero. It resets to zero.
- R2: Index 0x01 always reads {8'h00, NumPins-1, 8'h00, 8'h11}. Writes to it have no effect.
- R3: Index 0x02 reads {4'b0, id[3:0], 24'b0}, where the 4-bit field follows the last value written to bits 27:24 of index 0x00. A direct write to 0x02 has no effect.
- R4: Pin n uses index 0x10+2n for its low word and 0x10+2n+1 for its high word.
  - Low word fields: vector [7:0], delivery mode [10:8], destination mode [11], busy [12] (read-only), polarity [13], remote-service flag [14] (read-only), trigger [15] (1 = level) and mask [16]. Other bits read zero.
  - High word: only the destination [31:24] is held, so writing the high word changes nothing else.
  - After reset the low word reads 0x00010000 and the high word reads 0.
  - Any index that is not listed in R1 to R4 reads zero.
- R5: An edge-sensitive pin that is not masked produces exactly one message for each rising edge of its effective input, which is irqIn XOR polarity. An input held high produces no further messages. An edge that occurs while the pin is masked is discarded and is not delivered after unmasking. Changing the polarity while masked produces no message.
- R6: When a message from a level-sensitive pin is accepted, the pin's remote-service flag is set. While the flag is set, the pin produces no message, even if the input drops and rises again.
- R7: When eoiValid is high with an eoiVector equal to a level entry's vector, that entry's remote-service flag clears. A different vector leaves the flag set. If the input is still active, a new message follows without any mask step.
- R8: A level input that becomes active while its pin is masked is delivered once the mask is cleared, provided the input is still active.
- R9: Each message carries the entry's vector, destination, destination mode (0 = one target ID, 1 = destination is a bitmask), delivery mode, and msgLevel = trigger bit.
- R10: Rewriting the destination of an entry whose remote-service flag is set does not stop the next matching end-of-interrupt from clearing that flag.
- R11: When several pins request service, the first requester found scanning upward from the pin after the last accepted pin is presented (the scan wraps past the top pin). After reset the scan starts at pin 0.
- R12: Only one message is presented at a time. While msgValid is high and msgReady is low, msgValid and all message fields hold. A message is accepted on a cycle with msgValid and msgReady both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| selWr | input | 1 | Load the index register from selData |
| selData | input | 8 | Index value to load |
| dataWr | input | 1 | Write dataIn into the word selected by the index |
| dataIn | input | 32 | Write data |
| dataOut | output | 32 | Word selected by the current index |
| irqIn | input | NumPins | Device interrupt inputs |
| eoiValid | input | 1 | End-of-interrupt broadcast strobe |
| eoiVector | input | 8 | Vector being retired |
| msgValid | output | 1 | A message is presented |
| msgReady | input | 1 | The receiver accepts the message |
| msgVector | output | 8 | Message vector |
| msgDest | output | 8 | Message destination ID or bitmask |
| msgDestMode | output | 1 | 0 = one target ID, 1 = destination is a bitmask |
| msgLevel | output | 1 | The message came from a level-sensitive pin |
| msgDelivMode | output | 3 | Delivery mode copied from the entry |

## Verification
Some behaviour is checked by properties on every cycle:
- a presented message holds its fields and stays valid until accepted;
- an accepted message is followed by an idle cycle;
- a set remote-service flag persists until a matching end-of-interrupt arrives;
- a matching end-of-interrupt clears the flag whatever the destination field holds;
- a masked pin holds no stored edge;
- the arbitration field ignores direct writes.

Other behaviour only the bench scenarios can show:
- the exact message counts for edges, coalesced level pulses and re-triggering;
- the scan order across a wrap;
- the read-back encodings;
- delivery on unmask.

// File: rtl/irq_redir_pkg.sv
package irq_redir_pkg;

  // Fields held for one pin's routing entry.
  typedef struct packed {
    logic [7:0] dest;
    logic       mask;
    logic       trigLevel;
    logic       polarity;
    logic       destMode;
    logic [2:0] delivMode;
    logic [7:0] vector;
  } redirEntry_t;

  // Strobes from the control side to the register datapath.
  typedef struct packed {
    logic       accept;
    logic [7:0] pin;
  } ctrlStrobe_t;

  localparam logic [7:0] VersionCode = 8'h11;
  localparam logic [7:0] EntryBase   = 8'h10;
  localparam logic [7:0] IdxId       = 8'h00;
  localparam logic [7:0] IdxVersion  = 8'h01;
  localparam logic [7:0] IdxArb      = 8'h02;

endpackage

// File: rtl/irq_redir_regs.sv
module irq_redir_regs
  import irq_redir_pkg::*;
#(
  parameter int NumPins = 24
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                selWr,
  input  logic [7:0]          selData,
  input  logic                dataWr,
  input  logic [31:0]         dataIn,
  output logic [31:0]         dataOut,
  input  logic                eoiValid,
  input  logic [7:0]          eoiVector,
  input  ctrlStrobe_t         strobe,
  input  logic [NumPins-1:0]  busy,
  output redirEntry_t         entries [NumPins],
  output logic [NumPins-1:0]  irr
);

  localparam int PinW     = (NumPins > 1) ? $clog2(NumPins) : 1;
  localparam int EntryEnd = 16 + 2 * NumPins;

  logic [7:0]      idxQ;
  logic [3:0]      idQ;
  logic [3:0]      arbQ;
  logic            isEntry;
  logic [7:0]      entryOff;
  logic [PinW-1:0] pinSel;
  redirEntry_t     rdE;
  logic            unusedBits;

  assign isEntry  = (idxQ >= EntryBase) && (int'(idxQ) < EntryEnd);
  assign entryOff = (idxQ - EntryBase) >> 1;
  assign pinSel   = entryOff[PinW-1:0];
  assign unusedBits = ^{dataIn[23:17], dataIn[14], dataIn[12], entryOff[7:PinW]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idxQ <= '0;
    end else if (selWr) begin
      idxQ <= selData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idQ  <= '0;
      arbQ <= '0;
    end else if (dataWr && idxQ == IdxId) begin
      idQ  <= dataIn[27:24];
      arbQ <= dataIn[27:24];
    end
  end

  for (genvar n = 0; n < NumPins; n++) begin : g_pin
    redirEntry_t entR;
    logic        irrR;
    logic        wrLo;
    logic        wrHi;
    logic        eoiHit;
    logic        accHit;

    assign wrLo   = dataWr && isEntry && (pinSel == PinW'(n)) && !idxQ[0];
    assign wrHi   = dataWr && isEntry && (pinSel == PinW'(n)) && idxQ[0];
    assign eoiHit = eoiValid && (eoiVector == entR.vector);
    assign accHit = strobe.accept && (strobe.pin == 8'(n));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        entR      <= '0;
        entR.mask <= 1'b1;
      end else begin
        if (wrLo) begin
          entR.vector    <= dataIn[7:0];
          entR.delivMode <= dataIn[10:8];
          entR.destMode  <= dataIn[11];
          entR.polarity  <= dataIn[13];
          entR.trigLevel <= dataIn[15];
          entR.mask      <= dataIn[16];
        end
        if (wrHi) begin
          entR.dest <= dataIn[31:24];
        end
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        irrR <= 1'b0;
      end else if (!entR.trigLevel) begin
        irrR <= 1'b0;
      end else if (accHit) begin
        irrR <= 1'b1;
      end else if (eoiHit) begin
        irrR <= 1'b0;
      end
    end

    assign entries[n] = entR;
    assign irr[n]     = irrR;

    // R6: a set remote-service flag persists until a matching end-of-interrupt
    a_r6_irr_holds: assert property (@(posedge clk) disable iff (!rstN)
      (irrR && entR.trigLevel && !eoiHit) |=> irrR);

    // R7 / R10: a matching end-of-interrupt clears the flag, whatever the destination holds
    a_r10_eoi_clears: assert property (@(posedge clk) disable iff (!rstN)
      (irrR && eoiHit && !accHit) |=> !irrR);
  end

  always_comb begin
    dataOut = '0;
    rdE     = entries[pinSel];
    if (isEntry) begin
      if (idxQ[0]) begin
        dataOut = {rdE.dest, 24'b0};
      end else begin
        dataOut = {15'b0, rdE.mask, rdE.trigLevel, irr[pinSel], rdE.polarity,
                   busy[pinSel], rdE.destMode, rdE.delivMode, rdE.vector};
      end
    end else begin
      case (idxQ)
        IdxId:      dataOut = {4'b0, idQ, 24'b0};
        IdxVersion: dataOut = {8'h00, 8'(NumPins - 1), 8'h00, VersionCode};
        IdxArb:     dataOut = {4'b0, arbQ, 24'b0};
        default:    dataOut = '0;
      endcase
    end
  end

  // R3: direct writes leave the arbitration field unchanged
  a_r3_arb_ro: assert property (@(posedge clk) disable iff (!rstN)
    (dataWr && idxQ == IdxArb) |=> $stable(arbQ));

endmodule

// File: rtl/irq_redir_ctrl.sv
module irq_redir_ctrl
  import irq_redir_pkg::*;
#(
  parameter int NumPins = 24
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NumPins-1:0]  irqIn,
  input  redirEntry_t         entries [NumPins],
  input  logic [NumPins-1:0]  irr,
  input  logic                msgReady,
  output ctrlStrobe_t         strobe,
  output logic [NumPins-1:0]  busy,
  output logic                msgValid,
  output logic [7:0]          msgVector,
  output logic [7:0]          msgDest,
  output logic                msgDestMode,
  output logic                msgLevel,
  output logic [2:0]          msgDelivMode
);

  localparam int PinW = (NumPins > 1) ? $clog2(NumPins) : 1;

  logic [NumPins-1:0] effIn;
  logic [NumPins-1:0] prevQ;
  logic [NumPins-1:0] pendQ;
  logic [NumPins-1:0] req;
  logic               accept;
  logic               anyReq;
  logic [PinW-1:0]    grantPin;
  logic               validQ;
  logic [PinW-1:0]    pinQ;
  logic [PinW-1:0]    lastQ;
  redirEntry_t        msgQ;
  int                 cand;

  assign accept = validQ && msgReady;

  for (genvar n = 0; n < NumPins; n++) begin : g_pin
    logic risen;
    assign effIn[n] = irqIn[n] ^ entries[n].polarity;
    assign risen    = effIn[n] && !prevQ[n];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        pendQ[n] <= 1'b0;
      end else if (entries[n].mask || entries[n].trigLevel) begin
        pendQ[n] <= 1'b0;
      end else begin
        pendQ[n] <= risen || (pendQ[n] && !(accept && pinQ == PinW'(n)));
      end
    end

    assign req[n]  = entries[n].trigLevel ? (effIn[n] && !entries[n].mask && !irr[n])
                                          : pendQ[n];
    assign busy[n] = req[n] || (validQ && pinQ == PinW'(n));

    // R5: a masked pin keeps no stored edge
    a_r5_masked_drop: assert property (@(posedge clk) disable iff (!rstN)
      entries[n].mask |=> !pendQ[n]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevQ <= '0;
    end else begin
      prevQ <= effIn;
    end
  end

  // Round-robin scan starting after the last accepted pin.
  always_comb begin
    anyReq   = 1'b0;
    grantPin = '0;
    cand     = 0;
    for (int k = 1; k <= NumPins; k++) begin
      cand = int'(lastQ) + k;
      if (cand >= NumPins) cand = cand - NumPins;
      if (!anyReq && req[cand]) begin
        anyReq   = 1'b1;
        grantPin = PinW'(cand);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= 1'b0;
      pinQ   <= '0;
      lastQ  <= PinW'(NumPins - 1);
      msgQ   <= '0;
    end else if (accept) begin
      validQ <= 1'b0;
      lastQ  <= pinQ;
    end else if (!validQ && anyReq) begin
      validQ <= 1'b1;
      pinQ   <= grantPin;
      msgQ   <= entries[grantPin];
    end
  end

  assign strobe.accept = accept;
  assign strobe.pin    = 8'(pinQ);
  assign msgValid      = validQ;
  assign msgVector     = msgQ.vector;
  assign msgDest       = msgQ.dest;
  assign msgDestMode   = msgQ.destMode;
  assign msgLevel      = msgQ.trigLevel;
  assign msgDelivMode  = msgQ.delivMode;

  // R12: a presented message holds until accepted
  a_r12_hold: assert property (@(posedge clk) disable iff (!rstN)
    (validQ && !msgReady) |=> (validQ && $stable(msgVector) && $stable(msgDest)
                               && $stable(pinQ) && $stable(msgLevel)));

  // R12: an accepted message is followed by an idle cycle
  a_r12_one_at_a_time: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> !validQ);

  // R11: the presented pin is always an implemented one
  a_r11_pin_range: assert property (@(posedge clk) disable iff (!rstN)
    validQ |-> (int'(pinQ) < NumPins));

endmodule

// File: rtl/irq_redirector.sv
module irq_redirector
  import irq_redir_pkg::*;
#(
  parameter int NumPins = 24
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               selWr,
  input  logic [7:0]         selData,
  input  logic               dataWr,
  input  logic [31:0]        dataIn,
  output logic [31:0]        dataOut,
  input  logic [NumPins-1:0] irqIn,
  input  logic               eoiValid,
  input  logic [7:0]         eoiVector,
  output logic               msgValid,
  input  logic               msgReady,
  output logic [7:0]         msgVector,
  output logic [7:0]         msgDest,
  output logic               msgDestMode,
  output logic               msgLevel,
  output logic [2:0]         msgDelivMode
);

  ctrlStrobe_t        strobe;
  redirEntry_t        entries [NumPins];
  logic [NumPins-1:0] irr;
  logic [NumPins-1:0] busy;

  irq_redir_regs #(.NumPins(NumPins)) i_regs (
    .clk       (clk),
    .rstN      (rstN),
    .selWr     (selWr),
    .selData   (selData),
    .dataWr    (dataWr),
    .dataIn    (dataIn),
    .dataOut   (dataOut),
    .eoiValid  (eoiValid),
    .eoiVector (eoiVector),
    .strobe    (strobe),
    .busy      (busy),
    .entries   (entries),
    .irr       (irr)
  );

  irq_redir_ctrl #(.NumPins(NumPins)) i_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .irqIn        (irqIn),
    .entries      (entries),
    .irr          (irr),
    .msgReady     (msgReady),
    .strobe       (strobe),
    .busy         (busy),
    .msgValid     (msgValid),
    .msgVector    (msgVector),
    .msgDest      (msgDest),
    .msgDestMode  (msgDestMode),
    .msgLevel     (msgLevel),
    .msgDelivMode (msgDelivMode)
  );

endmodule

// File: tb/test_irq_redirector.sv
module test_irq_redirector;

  localparam int ClkPeriod = 10;
  localparam int NumPins   = 24;

  typedef struct packed {
    logic        wr;
    logic [7:0]  idx;
    logic [31:0] data;
    logic [31:0] exp;
  } regVec_t;

  // Register vectors: writes carry exp = 0 and are not checked.
  localparam regVec_t Tbl [18] = '{
    '{1'b1, 8'h00, 32'hFFFFFFFF, 32'h0},        // R1
    '{1'b0, 8'h00, 32'h0,        32'h0F000000}, // R1
    '{1'b1, 8'h00, 32'hF0FFFFFF, 32'h0},        // R1
    '{1'b0, 8'h00, 32'h0,        32'h00000000}, // R1
    '{1'b1, 8'h00, 32'h0A000000, 32'h0},        // R3
    '{1'b0, 8'h02, 32'h0,        32'h0A000000}, // R3
    '{1'b1, 8'h02, 32'h00000000, 32'h0},        // R3
    '{1'b0, 8'h02, 32'h0,        32'h0A000000}, // R3
    '{1'b1, 8'h01, 32'hFFFFFFFF, 32'h0},        // R2
    '{1'b0, 8'h01, 32'h0,        32'h00170011}, // R2
    '{1'b1, 8'h13, 32'hFFFFFFFF, 32'h0},        // R4
    '{1'b0, 8'h13, 32'h0,        32'hFF000000}, // R4
    '{1'b0, 8'h12, 32'h0,        32'h00010000}, // R4
    '{1'b1, 8'h12, 32'hFFFFFFFF, 32'h0},        // R4
    '{1'b0, 8'h12, 32'h0,        32'h0001AFFF}, // R4
    '{1'b1, 8'h12, 32'h00010000, 32'h0},        // R4
    '{1'b0, 8'h05, 32'h0,        32'h00000000}, // R4
    '{1'b0, 8'h40, 32'h0,        32'h00000000}  // R4
  };

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               selWr = 1'b0;
  logic [7:0]         selData = '0;
  logic               dataWr = 1'b0;
  logic [31:0]        dataIn = '0;
  logic [31:0]        dataOut;
  logic [NumPins-1:0] irqIn = '0;
  logic               eoiValid = 1'b0;
  logic [7:0]         eoiVector = '0;
  logic               msgValid;
  logic               msgReady = 1'b1;
  logic [7:0]         msgVector;
  logic [7:0]         msgDest;
  logic               msgDestMode;
  logic               msgLevel;
  logic [2:0]         msgDelivMode;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  int         msgCnt = 0;
  logic [7:0] lastVec = '0, prevVec = '0, lastDest = '0;
  logic       lastDm = 1'b0, lastLvl = 1'b0;
  logic [2:0] lastDeliv = '0;

  always #(ClkPeriod / 2) clk = ~clk;

  irq_redirector #(.NumPins(NumPins)) i_irq_redirector (
    .clk(clk), .rstN(rstN), .selWr(selWr), .selData(selData), .dataWr(dataWr),
    .dataIn(dataIn), .dataOut(dataOut), .irqIn(irqIn), .eoiValid(eoiValid),
    .eoiVector(eoiVector), .msgValid(msgValid), .msgReady(msgReady),
    .msgVector(msgVector), .msgDest(msgDest), .msgDestMode(msgDestMode),
    .msgLevel(msgLevel), .msgDelivMode(msgDelivMode)
  );

  // Message monitor: records every accepted message.
  always @(posedge clk) begin
    if (rstN && msgValid && msgReady) begin
      msgCnt    <= msgCnt + 1;
      prevVec   <= lastVec;
      lastVec   <= msgVector;
      lastDest  <= msgDest;
      lastDm    <= msgDestMode;
      lastLvl   <= msgLevel;
      lastDeliv <= msgDelivMode;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setIdx(input logic [7:0] i);
    @(negedge clk);
    selWr = 1'b1; selData = i;
    @(negedge clk);
    selWr = 1'b0;
  endtask

  task automatic wrReg(input logic [7:0] i, input logic [31:0] d);
    setIdx(i);
    dataWr = 1'b1; dataIn = d;
    @(negedge clk);
    dataWr = 1'b0;
  endtask

  task automatic rdReg(input logic [7:0] i, output logic [31:0] d);
    setIdx(i);
    d = dataOut;
  endtask

  task automatic sendEoi(input logic [7:0] v);
    @(negedge clk);
    eoiValid = 1'b1; eoiVector = v;
    @(negedge clk);
    eoiValid = 1'b0;
  endtask

  task automatic pulse(input int p);
    @(negedge clk);
    irqIn[p] = 1'b1;
    @(negedge clk);
    irqIn[p] = 1'b0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: got %h expected %h", 32'd0, 32'd1);
    finishRun();
  end

  initial begin
    logic [31:0] rd;
    waitCyc(3);
    rstN = 1'b1;
    waitCyc(1);

    // Reset state
    chk("R12 reset idle", {31'b0, msgValid}, 32'd0);
    rdReg(8'h10, rd); chk("R4 reset entry", rd, 32'h00010000);
    rdReg(8'h11, rd); chk("R4 reset high", rd, 32'h0);
    rdReg(8'h00, rd); chk("R1 reset id", rd, 32'h0);

    // Register vector walk
    for (int i = 0; i < 18; i++) begin
      if (Tbl[i].wr) wrReg(Tbl[i].idx, Tbl[i].data);
      else begin
        rdReg(Tbl[i].idx, rd);
        chk($sformatf("R1-4 table[%0d]", i), rd, Tbl[i].exp);
      end
    end

    // R5 / R9: edge pin 4, physical destination 5
    wrReg(8'h19, 32'h05000000);
    wrReg(8'h18, 32'h00000040);
    pulse(4); waitCyc(6);
    chk("R5 edge count", msgCnt, 1);
    chk("R9 vector", lastVec, 8'h40);
    chk("R9 dest", lastDest, 8'h05);
    chk("R9 physical mode", lastDm, 1'b0);
    chk("R9 edge flag", lastLvl, 1'b0);
    @(negedge clk); irqIn[4] = 1'b1; waitCyc(8);
    chk("R5 held high once", msgCnt, 2);
    irqIn[4] = 1'b0; waitCyc(2);
    wrReg(8'h18, 32'h00010040);
    pulse(4); waitCyc(4);
    wrReg(8'h18, 32'h00000040); waitCyc(6);
    chk("R5 masked edge dropped", msgCnt, 2);

    // R6 / R7: level pin 6, vector 0x60
    wrReg(8'h1D, 32'h02000000);
    wrReg(8'h1C, 32'h00008060);
    @(negedge clk); irqIn[6] = 1'b1; waitCyc(6);
    chk("R6 level delivered", msgCnt, 3);
    chk("R9 level flag", lastLvl, 1'b1);
    rdReg(8'h1C, rd); chk("R6 remote flag set", rd, 32'h0000C060);
    irqIn[6] = 1'b0; waitCyc(2); irqIn[6] = 1'b1; waitCyc(6);
    chk("R6 coalesced", msgCnt, 3);
    sendEoi(8'h61); waitCyc(4);
    rdReg(8'h1C, rd); chk("R7 other vector keeps flag", rd, 32'h0000C060);
    chk("R7 no message on other vector", msgCnt, 3);
    sendEoi(8'h60); waitCyc(6);
    chk("R7 retrigger after eoi", msgCnt, 4);
    irqIn[6] = 1'b0;
    sendEoi(8'h60); waitCyc(3);
    rdReg(8'h1C, rd); chk("R7 flag cleared", rd, 32'h00008060);
    chk("R7 no message when idle", msgCnt, 4);

    // R10: destination rewrite while in service
    wrReg(8'h1F, 32'h0);
    wrReg(8'h1E, 32'h00008070);
    @(negedge clk); irqIn[7] = 1'b1; waitCyc(6);
    chk("R10 delivered", msgCnt, 5);
    irqIn[7] = 1'b0;
    wrReg(8'h1F, 32'h01000000);
    sendEoi(8'h70); waitCyc(2);
    rdReg(8'h1E, rd); chk("R10 flag cleared", rd, 32'h00008070);

    // R8: level asserted while masked
    wrReg(8'h23, 32'h03000000);
    wrReg(8'h22, 32'h00018090);
    @(negedge clk); irqIn[9] = 1'b1; waitCyc(6);
    chk("R8 masked level held", msgCnt, 5);
    wrReg(8'h22, 32'h00008090); waitCyc(6);
    chk("R8 delivered on unmask", msgCnt, 6);
    chk("R8 vector", lastVec, 8'h90);
    irqIn[9] = 1'b0;

    // R9: logical destination bitmask, delivery mode 1
    wrReg(8'h27, 32'h0D000000);
    wrReg(8'h26, 32'h000009B0);
    pulse(11); waitCyc(6);
    chk("R9 logical count", msgCnt, 7);
    chk("R9 logical dest", lastDest, 8'h0D);
    chk("R9 logical mode", lastDm, 1'b1);
    chk("R9 delivery mode", lastDeliv, 3'd1);

    // R5: inverted polarity, configured while masked
    wrReg(8'h28, 32'h000120C0); waitCyc(2);
    wrReg(8'h28, 32'h000020C0); waitCyc(4);
    chk("R5 polarity no spurious", msgCnt, 7);
    @(negedge clk); irqIn[12] = 1'b1; waitCyc(2);
    irqIn[12] = 1'b0; waitCyc(6);
    chk("R5 polarity edge", msgCnt, 8);
    chk("R5 polarity vector", lastVec, 8'hC0);

    // R11 / R12: round-robin and handshake hold
    wrReg(8'h30, 32'h000000D0);
    wrReg(8'h1A, 32'h00000050);
    wrReg(8'h2E, 32'h000000F0);
    pulse(16); waitCyc(6);
    chk("R11 pin16 served", lastVec, 8'hD0);
    @(negedge clk); msgReady = 1'b0; irqIn[5] = 1'b1; irqIn[15] = 1'b1;
    @(negedge clk); irqIn[5] = 1'b0; irqIn[15] = 1'b0;
    waitCyc(4);
    chk("R11 wrap picks pin5", {msgValid, msgVector}, {1'b1, 8'h50});
    waitCyc(5);
    chk("R12 held while not ready", {msgValid, msgVector}, {1'b1, 8'h50});
    chk("R12 nothing accepted", msgCnt, 9);
    msgReady = 1'b1; waitCyc(6);
    chk("R11 both served", msgCnt, 11);
    chk("R11 order first", prevVec, 8'h50);
    chk("R11 order second", lastVec, 8'hF0);

    finishRun();
  end

endmodule